// File: doc/BRIEF.md
# OTP Protection Word Programmer

This block is the command front end for a small one-time-programmable area that sits beside a flash-style memory array. The area holds eight 16-bit user words (128 bits in all) and one lock word. Software talks to it with ordinary bus write and read cycles. A program operation takes two writes. The first write carries a setup code. The second write carries the target address and the data. The block then runs a program operation that lasts a fixed number of clock cycles.

Programming can only turn bits from 1 to 0. The stored word becomes the old word ANDed with the written data. Clearing bit 1 of the lock word closes the user area for good. After that, any attempt to program a user word leaves the data unchanged and raises an error flag in the status register. An operation that has started cannot be interrupted: every write that arrives while it runs is dropped. Reads return array contents in array mode. From the setup write until a read-array command, reads return the status register instead.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After synchronous reset, all eight user words and the lock word read 0xFFFF in array mode, the block is in array mode, the status error bit is 0, and rdata is 0x0000.
- R2: A program operation stores old AND data. Addresses 0 to 7 select the user words and address 8 selects the lock word.
- R3: A write whose low data byte is 0xC0 enters setup mode. The next write supplies the address and data and starts the operation. A first-cycle write with a code other than 0xC0 or 0x50 (0xFF included) selects array mode and programs nothing.
- R4: A read presented with rd_en at a clock edge updates rdata after that edge. In array mode rdata is the addressed word, or 0x0000 for addresses above 8. In setup, busy and status modes rdata is the status word: bit 7 ready, bit 4 program error, all other bits 0.
- R5: While bit 1 of the lock word is 0, a program to addresses 0 to 7 changes no data and sets status bit 4. The lock word itself stays programmable, still under the 1-to-0 rule.
- R6: Reads return ready = 0 during the PROG_CYCLES clock cycles that follow the edge that latched the second write. The data change and ready = 1 are visible from the next cycle on.
- R7: While busy, every write is ignored, including a suspend code 0xB0, a read-array code 0xFF and a setup code 0xC0. The operation completes on time.
- R8: Status bit 4 stays set until a 0x50 write outside busy and setup clears it. A 0x50 write leaves the mode unchanged. A 0xFF write does not clear the bit.
- R9: A second-cycle address above 8 sets status bit 4 and leaves all stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Word address for reads and for the second program write |
| wdata | input | DATA_W | Write data; the low byte carries the command code |
| rdata | output | DATA_W | Registered read data: an array word or the status word |

## Verification
The bench runs a behavioural model alongside the design and compares rdata after every clock. This catches an off-by-one busy window, which would show ready one cycle early or late around the end of an operation. The bench programs the same word twice with overlapping patterns; a design that overwrote the word instead of ANDing it would read back the second pattern alone. The bench locks the area and then programs a user word; a lock check that was skipped or taken from the wrong bit would change the word or leave the error bit clear. Suspend, setup and read-array codes written while busy would, if obeyed, cut the busy window short or bring back array data in the middle of the operation.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_SETUP  = 2'd1,
    MODE_BUSY   = 2'd2,
    MODE_STATUS = 2'd3
  } otp_mode_t;

  localparam logic [7:0] CODE_SETUP = 8'hC0;
  localparam logic [7:0] CODE_CLEAR = 8'h50;
  localparam logic [7:0] CODE_ARRAY = 8'hFF;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_ERR_BIT   = 4;
endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
  parameter int CYCLES = 16,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  // R6: the window ends exactly once, on done
  assert_done_ends_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R6: busy cannot drop early
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store #(
  parameter int DATA_W    = 16,
  parameter int OTP_WORDS = 8,
  parameter int ADDR_W    = 4,
  parameter int LOCK_BIT  = 1,
  localparam int N_WORDS  = OTP_WORDS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [DATA_W-1:0] commit_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              locked
);
  logic [DATA_W-1:0] words [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    logic hit;
    assign hit = commit && (commit_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '1;
      end else if (hit) begin
        words[i] <= words[i] & commit_data;
      end
    end

    // R2: a stored bit never goes from 0 back to 1
    assert_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
      (words[i] & ~$past(words[i])) == '0);

    if (i < OTP_WORDS) begin : g_user
      // R5: a closed area keeps its user words
      assert_locked_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> $stable(words[i]));
    end
  end

  assign locked = ~words[OTP_WORDS][LOCK_BIT];

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_word = words[k];
    end
  end
endmodule

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int LOCK_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              locked,
  input  logic              done,
  output logic              start,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output otp_mode_t         mode,
  output logic              err
);
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_data;
  logic              p_bad;
  logic              bad_now;
  logic [7:0]        code;

  assign code    = wr_data[7:0];
  assign bad_now = (wr_addr > ADDR_W'(LOCK_ADDR)) ||
                   ((wr_addr < ADDR_W'(LOCK_ADDR)) && locked);
  assign start   = wr_en && (mode == MODE_SETUP);
  assign commit  = done && !p_bad;
  assign commit_addr = p_addr;
  assign commit_data = p_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_ARRAY;
      err    <= 1'b0;
      p_addr <= '0;
      p_data <= '1;
      p_bad  <= 1'b0;
    end else begin
      case (mode)
        MODE_SETUP: begin
          if (wr_en) begin
            p_addr <= wr_addr;
            p_data <= wr_data;
            p_bad  <= bad_now;
            mode   <= MODE_BUSY;
          end
        end
        MODE_BUSY: begin
          if (done) begin
            mode <= MODE_STATUS;
            if (p_bad) err <= 1'b1;
          end
        end
        default: begin
          if (wr_en) begin
            case (code)
              CODE_SETUP: mode <= MODE_SETUP;
              CODE_CLEAR: err  <= 1'b0;
              CODE_ARRAY: mode <= MODE_ARRAY;
              default:    mode <= MODE_ARRAY;
            endcase
          end
        end
      endcase
    end
  end

  // R7: nothing but the timer ends the busy mode
  assert_busy_uninterrupted_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BUSY && !done) |=> (mode == MODE_BUSY));
  // R8: the error flag only falls on a clear code outside setup and busy
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err && !(wr_en && code == CODE_CLEAR &&
              (mode == MODE_ARRAY || mode == MODE_STATUS))) |=> err);
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int OTP_WORDS   = 8,
  parameter int ADDR_W      = 4,
  parameter int LOCK_BIT    = 1,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LOCK_ADDR = OTP_WORDS;

  initial begin
    assert ((2 ** ADDR_W) > LOCK_ADDR && PROG_CYCLES >= 1)
      else $error("otp_prog_ctrl: parameter set out of range");
  end

  logic              start, busy, done, commit, locked, err;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data, rd_word, status;
  otp_mode_t         mode;

  otp_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  otp_cmd_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
    .locked(locked), .done(done), .start(start), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data), .mode(mode), .err(err)
  );

  otp_word_store #(.DATA_W(DATA_W), .OTP_WORDS(OTP_WORDS), .ADDR_W(ADDR_W),
                   .LOCK_BIT(LOCK_BIT)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .commit_addr(commit_addr),
    .commit_data(commit_data), .rd_addr(addr), .rd_word(rd_word), .locked(locked)
  );

  always_comb begin
    status = '0;
    status[STAT_READY_BIT] = (mode != MODE_BUSY);
    status[STAT_ERR_BIT]   = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (mode == MODE_ARRAY) ? rd_word : status;
    end
  end

  // R4: a read taken while busy reports not ready
  assert_busy_read_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(busy)) |-> !rdata[STAT_READY_BIT]);
endmodule

// File: tb/otp_prog_ctrl_tb.sv
module otp_prog_ctrl_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  otp_prog_ctrl #(.PROG_CYCLES(N)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // behavioural model: 0 array, 1 setup, 2 busy, 3 status
  int m_mode, m_cnt, m_err, m_paddr;
  int m_mem[9];
  int m_pdata;
  int exp_rdata;

  function automatic int m_status();
    return ((m_mode != 2) ? 32'h80 : 0) | (m_err ? 32'h10 : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_err = 0; exp_rdata = 0;
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
    end else begin
      if (rd_en) begin
        if (m_mode != 0) exp_rdata = m_status();
        else exp_rdata = (addr <= 8) ? m_mem[addr] : 0;
      end
      if (m_mode == 2) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_mode = 3;
          if (m_paddr > 8 || (m_paddr < 8 && ((m_mem[8] >> 1) & 1) == 0)) m_err = 1;
          else m_mem[m_paddr] = m_mem[m_paddr] & m_pdata;
        end
      end else if (wr_en) begin
        if (m_mode == 1) begin
          m_paddr = addr; m_pdata = wdata; m_mode = 2; m_cnt = N;
        end else if (wdata[7:0] == 8'hC0) m_mode = 1;
        else if (wdata[7:0] == 8'h50) m_err = 0;
        else m_mode = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      checks++;
      if (rdata !== 16'(exp_rdata)) begin
        errors++;
        $display("FAIL %s cycle compare: actual %h expected %h", tag, rdata, 16'(exp_rdata));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(input logic [15:0] e, input string req);
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s direct: actual %h expected %h", req, rdata, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    chk(16'h0000, "R1");
    for (int a = 0; a < 9; a++) begin
      rd(4'(a)); chk(16'hFFFF, "R1");
    end

    tag = "R4";
    rd(4'd12); chk(16'h0000, "R4");

    tag = "R2";
    wr(4'd0, 16'h00C0);
    rd(4'd3); chk(16'h0080, "R4");
    wr(4'd3, 16'hA5F0);
    tag = "R6";
    rd(4'd3); chk(16'h0000, "R6");
    idle(N - 5);
    rd(4'd3);
    rd(4'd3);
    rd(4'd3); chk(16'h0080, "R6");
    tag = "R2";
    wr(4'd0, 16'h00FF);
    rd(4'd3); chk(16'hA5F0, "R2");
    wr(4'd0, 16'h00C0); wr(4'd3, 16'h0FFF); idle(N + 1);
    wr(4'd0, 16'h00FF);
    rd(4'd3); chk(16'h05F0, "R2");

    tag = "R3";
    wr(4'd0, 16'h0020);
    wr(4'd5, 16'h0000);
    rd(4'd5); chk(16'hFFFF, "R3");

    tag = "R9";
    wr(4'd0, 16'h00C0); wr(4'd9, 16'h0000); idle(N + 1);
    rd(4'd0); chk(16'h0090, "R9");
    tag = "R8";
    wr(4'd0, 16'h00FF);
    rd(4'd0); chk(16'hFFFF, "R9");
    wr(4'd0, 16'h00C0); rd(4'd0); chk(16'h0090, "R8");
    wr(4'd15, 16'h0000); idle(N + 1);
    wr(4'd0, 16'h0050);
    rd(4'd0); chk(16'h0080, "R8");

    tag = "R7";
    wr(4'd0, 16'h00FF);
    wr(4'd0, 16'h00C0); wr(4'd6, 16'h00FF);
    wr(4'd0, 16'h00B0);
    wr(4'd0, 16'h00FF);
    wr(4'd6, 16'h00C0);
    rd(4'd6); chk(16'h0000, "R7");
    idle(N);
    rd(4'd6); chk(16'h0080, "R7");
    wr(4'd0, 16'h00FF);
    rd(4'd6); chk(16'h00FF, "R7");

    tag = "R5";
    wr(4'd0, 16'h00C0); wr(4'd8, 16'hFFFD); idle(N + 1);
    wr(4'd0, 16'h00C0); wr(4'd0, 16'h0000); idle(N + 1);
    rd(4'd0); chk(16'h0090, "R5");
    wr(4'd0, 16'h0050); wr(4'd0, 16'h00FF);
    rd(4'd0); chk(16'hFFFF, "R5");
    wr(4'd0, 16'h00C0); wr(4'd8, 16'hFFFE); idle(N + 1);
    rd(4'd0); chk(16'h0080, "R5");
    wr(4'd0, 16'h00FF);
    rd(4'd8); chk(16'hFFFC, "R5");

    idle(3);
    finish_run();
  end
endmodule